// File: doc/BRIEF.md
# Banked Interrupt Control State and Group Decoder

This block keeps the global control state of an interrupt distributor: a flag that turns off the two-world security model, an enable for each of the three interrupt groups (secure group 0, non-secure group 1, secure group 1), and a routing-enable indication that always reads as on. Secure and non-secure accesses see one control word in two different ways. A non-secure agent sees only the non-secure group 1 enable and the routing flag. A secure agent sees and changes everything. Once security is turned off, every agent sees a single common layout.

Next to the control word, the block turns each interrupt's group bit and group-modifier bit into a 2-bit group code. It also reports, for each interrupt, whether the group it belongs to is currently enabled. The priority and routing logic downstream uses these per-interrupt outputs to decide whether a pending interrupt may be forwarded.

The control word is read combinationally. A write takes effect at the next rising clock edge when `reg_wr` is high.

Top module: `irq_ctl_bank`

## Requirements
- R1: After reset, the security-off flag and all three group enables are 0. The secure read view is then 0x30 and the non-secure read view is 0x10.
- R2: While security is off, a read from either side returns: bit 6 = security-off flag (1), bit 4 = 1, bit 1 = non-secure group 1 enable, bit 0 = group 0 enable. All other bits are 0.
- R3: While security is on, a non-secure read returns bit 4 = 1 and bit 1 = non-secure group 1 enable. All other bits are 0.
- R4: While security is on, a secure read returns: bit 0 = group 0 enable, bit 1 = non-secure group 1 enable, bit 2 = secure group 1 enable, bits 4 and 5 = 1. All other bits are 0.
- R5: While security is on, a non-secure write loads only the non-secure group 1 enable, from bit 1 of the write data. Every other piece of state keeps its value.
- R6: While security is on, a secure write loads the security-off flag from bit 6, the secure group 1 enable from bit 2, the non-secure group 1 enable from bit 1 and the group 0 enable from bit 0. Bits 4 and 5 still read 1 after a write of 0 to them.
- R7: While security is off, a write from either side loads the group 0 enable from bit 0 and the non-secure group 1 enable from bit 1. The security-off flag stays 1 until reset, and the secure group 1 enable keeps its value.
- R8: While security is off, the group code of interrupt i is 1 (non-secure group 1) when its group bit is 1, and 0 (group 0) when its group bit is 0. The code is never 2.
- R9: While security is on, the group code is formed from (modifier, group) as follows: (0,0) gives 0 (group 0), (0,1) gives 1 (non-secure group 1), (1,0) gives 2 (secure group 1), and (1,1) gives 1. Code 3 never appears.
- R10: `irq_grp_on[i]` is 1 exactly when the enable that matches the group code of interrupt i is set.
- R11: In a cycle with `reg_wr` low, the control state does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Write strobe for the control word |
| reg_secure | input | 1 | Security attribute of the access (1 = secure) |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Banked read view of the control word |
| irq_grp_bit | input | NUM_IRQ | Group bit of each interrupt |
| irq_mod_bit | input | NUM_IRQ | Group-modifier bit of each interrupt |
| irq_group | output | 2*NUM_IRQ | Group code of each interrupt, 2 bits each, interrupt i at [2i+1:2i] |
| irq_grp_on | output | NUM_IRQ | Group of interrupt i is enabled |
| sec_disabled | output | 1 | Security-off flag |
| grp0_on | output | 1 | Group 0 enable |
| grp1ns_on | output | 1 | Non-secure group 1 enable |
| grp1s_on | output | 1 | Secure group 1 enable |

## Verification
The assertions check several properties on every cycle:
- a non-secure write never disturbs secure state;
- a secure write loads exactly the bits it names;
- the security-off flag stays set once set;
- the state holds when no write occurs;
- the decoder never produces the illegal code, nor the secure group 1 code while security is off;
- an interrupt is never reported as enabled when no group enable is set.

Only the bench scenarios can show the rest:
- the exact bit layouts of the three read views;
- each entry of the modifier/group decode table under many input patterns;
- that writing zeros to the routing bits leaves them reading as one.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  localparam int CTL_W       = 8;
  localparam int B_EN_G0     = 0;
  localparam int B_EN_G1NS   = 1;
  localparam int B_EN_G1S    = 2;
  localparam int B_ROUTE_S   = 4;
  localparam int B_ROUTE_NS  = 5;
  localparam int B_SEC_OFF   = 6;

  typedef enum logic [1:0] {
    GRP_SEC0 = 2'd0,
    GRP_NS1  = 2'd1,
    GRP_SEC1 = 2'd2
  } irq_grp_e;

  typedef struct packed {
    logic sec_off;
    logic g1s;
    logic g1ns;
    logic g0;
  } ctl_state_t;
endpackage

// File: rtl/irqc_ctl_regs.sv
module irqc_ctl_regs
  import irqc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic             acc_secure,
  input  logic [CTL_W-1:0] wr_data,
  output logic [CTL_W-1:0] rd_data,
  output ctl_state_t       state
);

  ctl_state_t cur_q, nxt_d;

  // next-state: what a write would load, by view
  always_comb begin
    nxt_d = cur_q;
    if (cur_q.sec_off) begin
      nxt_d.g0   = wr_data[B_EN_G0];
      nxt_d.g1ns = wr_data[B_EN_G1NS];
    end else if (acc_secure) begin
      nxt_d.sec_off = wr_data[B_SEC_OFF];
      nxt_d.g1s     = wr_data[B_EN_G1S];
      nxt_d.g1ns    = wr_data[B_EN_G1NS];
      nxt_d.g0      = wr_data[B_EN_G0];
    end else begin
      nxt_d.g1ns = wr_data[B_EN_G1NS];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_q <= '0;
    end else if (wr_en) begin
      cur_q <= nxt_d;
    end
  end

  // banked read view
  always_comb begin
    rd_data = '0;
    rd_data[B_ROUTE_S]  = 1'b1;
    rd_data[B_EN_G1NS]  = cur_q.g1ns;
    if (cur_q.sec_off) begin
      rd_data[B_SEC_OFF] = 1'b1;
      rd_data[B_EN_G0]   = cur_q.g0;
    end else if (acc_secure) begin
      rd_data[B_ROUTE_NS] = 1'b1;
      rd_data[B_EN_G1S]   = cur_q.g1s;
      rd_data[B_EN_G0]    = cur_q.g0;
    end
  end

  assign state = cur_q;

  AST_NS_WR_NARROW: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !acc_secure && !cur_q.sec_off) |=>
      (cur_q.g0 == $past(cur_q.g0)) && (cur_q.g1s == $past(cur_q.g1s)) &&
      !cur_q.sec_off && (cur_q.g1ns == $past(wr_data[B_EN_G1NS]))); // R5

  AST_SEC_WR_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && acc_secure && !cur_q.sec_off) |=>
      (cur_q.sec_off == $past(wr_data[B_SEC_OFF])) &&
      (cur_q.g1s == $past(wr_data[B_EN_G1S])) &&
      (cur_q.g0 == $past(wr_data[B_EN_G0]))); // R6

  AST_SECOFF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    cur_q.sec_off |=> (cur_q.sec_off && $stable(cur_q.g1s))); // R7

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(cur_q)); // R11

  AST_NS_RD_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    (!acc_secure && !cur_q.sec_off) |-> (rd_data[B_EN_G1S] == 1'b0) && (rd_data[B_EN_G0] == 1'b0)
      && rd_data[B_ROUTE_S]); // R3

endmodule

// File: rtl/irqc_grp_decode.sv
module irqc_grp_decode
  import irqc_pkg::*;
#(
  parameter int NUM_IRQ = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 sec_off,
  input  logic [NUM_IRQ-1:0]   grp_bit,
  input  logic [NUM_IRQ-1:0]   mod_bit,
  output logic [2*NUM_IRQ-1:0] grp_code
);

  for (genvar i = 0; i < NUM_IRQ; i++) begin : g_irq
    irq_grp_e code;

    always_comb begin
      if (grp_bit[i]) begin
        code = GRP_NS1;
      end else if (!sec_off && mod_bit[i]) begin
        code = GRP_SEC1;
      end else begin
        code = GRP_SEC0;
      end
    end

    assign grp_code[2*i +: 2] = code;

    AST_NO_SEC1_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      sec_off |-> (grp_code[2*i +: 2] != 2'd2)); // R8

    AST_CODE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
      grp_code[2*i +: 2] != 2'd3); // R9
  end

endmodule

// File: rtl/irq_ctl_bank.sv
module irq_ctl_bank
  import irqc_pkg::*;
#(
  parameter int NUM_IRQ = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 reg_wr,
  input  logic                 reg_secure,
  input  logic [7:0]           reg_wdata,
  output logic [7:0]           reg_rdata,
  input  logic [NUM_IRQ-1:0]   irq_grp_bit,
  input  logic [NUM_IRQ-1:0]   irq_mod_bit,
  output logic [2*NUM_IRQ-1:0] irq_group,
  output logic [NUM_IRQ-1:0]   irq_grp_on,
  output logic                 sec_disabled,
  output logic                 grp0_on,
  output logic                 grp1ns_on,
  output logic                 grp1s_on
);

  ctl_state_t st;

  irqc_ctl_regs u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (reg_wr),
    .acc_secure (reg_secure),
    .wr_data    (reg_wdata),
    .rd_data    (reg_rdata),
    .state      (st)
  );

  irqc_grp_decode #(.NUM_IRQ(NUM_IRQ)) u_dec (
    .clk      (clk),
    .rst_n    (rst_n),
    .sec_off  (st.sec_off),
    .grp_bit  (irq_grp_bit),
    .mod_bit  (irq_mod_bit),
    .grp_code (irq_group)
  );

  for (genvar i = 0; i < NUM_IRQ; i++) begin : g_en
    always_comb begin
      unique case (irq_group[2*i +: 2])
        GRP_SEC0: irq_grp_on[i] = st.g0;
        GRP_NS1:  irq_grp_on[i] = st.g1ns;
        GRP_SEC1: irq_grp_on[i] = st.g1s;
        default:  irq_grp_on[i] = 1'b0;
      endcase
    end
  end

  assign sec_disabled = st.sec_off;
  assign grp0_on      = st.g0;
  assign grp1ns_on    = st.g1ns;
  assign grp1s_on     = st.g1s;

  AST_EN_NEEDS_CTL: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_grp_on != '0) |-> (grp0_on || grp1ns_on || grp1s_on)); // R10

endmodule

// File: tb/irq_ctl_bank_test.sv
`timescale 1ns/1ps
module irq_ctl_bank_test;
  localparam int N = 8;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         reg_wr, reg_secure;
  logic [7:0]   reg_wdata, reg_rdata;
  logic [N-1:0] irq_grp_bit, irq_mod_bit, irq_grp_on;
  logic [2*N-1:0] irq_group;
  logic sec_disabled, grp0_on, grp1ns_on, grp1s_on;

  int checks = 0;
  int errors = 0;
  // reference model state
  int m_off = 0, m_g0 = 0, m_g1ns = 0, m_g1s = 0;

  always #2.5 clk = ~clk;

  irq_ctl_bank #(.NUM_IRQ(N)) uut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_secure(reg_secure),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .irq_grp_bit(irq_grp_bit), .irq_mod_bit(irq_mod_bit),
    .irq_group(irq_group), .irq_grp_on(irq_grp_on),
    .sec_disabled(sec_disabled), .grp0_on(grp0_on),
    .grp1ns_on(grp1ns_on), .grp1s_on(grp1s_on)
  );

  task automatic check(input string tag, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, got, exp);
    end
  endtask

  function automatic int exp_rd(input int sec);
    if (m_off != 0) return 64 + 16 + m_g1ns * 2 + m_g0;
    if (sec != 0)   return 32 + 16 + m_g1s * 4 + m_g1ns * 2 + m_g0;
    return 16 + m_g1ns * 2;
  endfunction

  function automatic int exp_code(input int g, input int m);
    if (g != 0) return 1;
    if (m_off == 0 && m != 0) return 2;
    return 0;
  endfunction

  task automatic compare(input string tag);
    int ecodes = 0;
    int eon = 0;
    string rtag, gtag;
    for (int i = 0; i < N; i++) begin
      int c = exp_code(int'(irq_grp_bit[i]), int'(irq_mod_bit[i]));
      ecodes += c << (2 * i);
      if ((c == 0 && m_g0 != 0) || (c == 1 && m_g1ns != 0) || (c == 2 && m_g1s != 0))
        eon += 1 << i;
    end
    rtag = (m_off != 0) ? "R2 read view" : (reg_secure ? "R4 read view" : "R3 read view");
    gtag = (m_off != 0) ? "R8 decode" : "R9 decode";
    check({tag, " ", rtag}, int'(reg_rdata), exp_rd(int'(reg_secure)));
    check({tag, " ", gtag}, int'(irq_group), ecodes);
    check({tag, " R10 group enabled"}, int'(irq_grp_on), eon);
    check({tag, " state"}, {28'd0, sec_disabled, grp1s_on, grp1ns_on, grp0_on},
          m_off * 8 + m_g1s * 4 + m_g1ns * 2 + m_g0);
  endtask

  task automatic step(input string tag, input logic wr, input logic sec,
                      input logic [7:0] d, input logic [N-1:0] g, input logic [N-1:0] m);
    @(negedge clk);
    reg_wr = wr; reg_secure = sec; reg_wdata = d; irq_grp_bit = g; irq_mod_bit = m;
    #1 compare(tag);
    @(posedge clk);
    if (rst_n && wr) begin
      if (m_off != 0) begin
        m_g0 = int'(d[0]); m_g1ns = int'(d[1]);
      end else if (sec) begin
        m_off = int'(d[6]); m_g1s = int'(d[2]); m_g1ns = int'(d[1]); m_g0 = int'(d[0]);
      end else begin
        m_g1ns = int'(d[1]);
      end
    end
  endtask

  initial begin
    for (int c = 0; c < 20000; c++) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    reg_wr = 0; reg_secure = 0; reg_wdata = 0; irq_grp_bit = 0; irq_mod_bit = 0;
    // R1 reset state, both views
    step("R1", 1'b1, 1'b1, 8'hFF, 8'h00, 8'h00);
    step("R1", 1'b0, 1'b0, 8'h00, 8'hFF, 8'h00);
    @(negedge clk); rst_n = 1'b1;
    step("R1", 1'b0, 1'b1, 8'h00, 8'h0F, 8'hF0);
    // R5 non-secure write touches only g1ns
    step("R5", 1'b1, 1'b0, 8'hFF, 8'h00, 8'h00);
    step("R5", 1'b0, 1'b1, 8'h00, 8'hA5, 8'h3C);
    step("R5", 1'b1, 1'b0, 8'hFD, 8'h00, 8'h00);
    step("R5", 1'b0, 1'b1, 8'h00, 8'h00, 8'hFF);
    // R6 secure write, then routing bits written as zero
    step("R6", 1'b1, 1'b1, 8'h07, 8'h00, 8'h00);
    step("R6", 1'b0, 1'b1, 8'h00, 8'hCC, 8'hAA);
    step("R6", 1'b0, 1'b0, 8'h00, 8'hCC, 8'hAA);
    step("R6", 1'b1, 1'b1, 8'h04, 8'h00, 8'h00);
    step("R6", 1'b0, 1'b1, 8'h00, 8'h0F, 8'h55);
    step("R6", 1'b1, 1'b1, 8'h01, 8'h00, 8'h00);
    // R9 full decode table, mixed enables
    for (int p = 0; p < 16; p++)
      step("R9", 1'b0, p[0], 8'h00, 8'(p * 37), 8'(p * 91 + 5));
    step("R9", 1'b1, 1'b1, 8'h06, 8'h00, 8'h00);
    for (int p = 0; p < 8; p++)
      step("R10", 1'b0, 1'b1, 8'h00, 8'(p * 29), 8'(p * 53 + 3));
    // R11 idle cycles with garbage data
    for (int p = 0; p < 4; p++)
      step("R11", 1'b0, p[0], 8'hFF, 8'h33, 8'hCC);
    // turn security off with secure group 1 enabled
    step("R6", 1'b1, 1'b1, 8'h45, 8'h00, 8'hFF);
    step("R2", 1'b0, 1'b0, 8'h00, 8'hF0, 8'hFF);
    step("R2", 1'b0, 1'b1, 8'h00, 8'h0F, 8'hFF);
    // R7 writes with security off
    step("R7", 1'b1, 1'b0, 8'h02, 8'h00, 8'h00);
    step("R7", 1'b0, 1'b1, 8'h00, 8'h5A, 8'hA5);
    step("R7", 1'b1, 1'b1, 8'h00, 8'h00, 8'h00);
    step("R7", 1'b0, 1'b0, 8'h00, 8'hFF, 8'hFF);
    step("R7", 1'b1, 1'b1, 8'h03, 8'h00, 8'h00);
    // R8 decode ignores modifier when security is off
    for (int p = 0; p < 8; p++)
      step("R8", 1'b0, p[1], 8'h00, 8'(p * 41), 8'(~(p * 19)));
    step("R11", 1'b0, 1'b0, 8'h00, 8'h00, 8'h00);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule